// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external 8K x 8 asynchronous static RAM. The host starts a transfer by raising a request while the controller reports ready. Each transfer carries a 13-bit address, a read/write flag and, for writes, one byte of data. When the transfer is a read, the byte taken from the memory comes back with a strobe that is high for one cycle.

On the memory side the controller drives two chip selects of opposite polarity, a write strobe, an output strobe, the address lines and the data bus. The bus driver has its own enable, so the data pins can be built as a tristate pad. Every transfer passes through three timed phases:

- a setup phase, which drives the address and both selects;
- an access phase, which pulses the write strobe or opens the memory's outputs;
- a recovery phase, which releases the selects and turns the bus around.

The number of cycles in each phase comes from the clock period and the chosen speed grade. Each phase is the grade's minimum time rounded up to whole cycles. All memory-side outputs are driven straight from flops.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and while idle, the controller meets these conditions: `ready_o` is 1, `mem_cs_n_o` is 1, `mem_cs_o` is 0, `mem_we_n_o` is 1, `mem_oe_n_o` is 1, `mem_data_oe_o` is 0 and `rvalid_o` is 0.
- R2: `ready_o` is high only in the idle phase. A transfer is accepted on a rising clock edge where `req_i` and `ready_o` are both 1. A `req_i` held while `ready_o` is 0 has no effect on the memory.
- R3: `mem_we_n_o` is 0 only while `mem_cs_n_o` is 0, `mem_cs_o` is 1 and `mem_oe_n_o` is 1. Each write strobe lasts at least the grade's minimum write pulse (40/60/70 ns for grade 0/1/2).
- R4: During a write, the address and data stay stable from the first setup cycle to the end of the write strobe. That span is at least the grade's address-to-end-of-write time (60/80/85 ns) and its data setup time (30/40/50 ns).
- R5: `mem_oe_n_o` is 0 only during the access phase of a read, with `mem_we_n_o` at 1. The read byte is sampled at the end of that phase. By then the address and selects have been valid for at least the grade's access time (70/100/120 ns), and the output strobe for at least 35/50/60 ns.
- R6: Every accepted read gives exactly one `rvalid_o` pulse, one cycle long, with `rdata_o` equal to the byte last written to that address. A write gives no pulse.
- R7: Two successive assertions of the chip selects are at least one cycle time apart (70/100/120 ns). After a read, the selects stay released for at least the output-release time (30/35/40 ns).
- R8: `mem_data_oe_o` is 1 only during the setup and access phases of a write. It is never 1 while `mem_oe_n_o` is 0, and never while the memory may still be driving the bus.
- R9: Each phase length is ceil(minimum time / clock period), and never less than 1 cycle. The write phases are:
  - access: the write pulse;
  - setup: the address-to-end-of-write time minus the access phase;
  - recovery: the cycle time minus the setup and access phases.

  The read phases are:
  - access: the output-enable time;
  - setup: the access time minus the access phase;
  - recovery: the larger of the release time and the remainder of the cycle time.

  `ready_o` comes back exactly setup+access+recovery cycles after the accepting edge: 7 cycles for a write and 10 for a read at grade 0 with a 10 ns clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host transfer request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Host address |
| wdata_i | input | 8 | Host write byte |
| ready_o | output | 1 | Controller idle, request may be accepted |
| rdata_o | output | 8 | Byte read from memory |
| rvalid_o | output | 1 | One-cycle strobe qualifying `rdata_o` |
| mem_cs_n_o | output | 1 | Memory chip select, active low |
| mem_cs_o | output | 1 | Memory chip select, active high |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_oe_n_o | output | 1 | Memory output strobe, active low |
| mem_addr_o | output | 13 | Memory address |
| mem_data_o | output | 8 | Byte driven onto the memory bus |
| mem_data_oe_o | output | 1 | Enable for the bus driver |
| mem_data_i | input | 8 | Byte seen on the memory bus |

## Verification
The assertions check the following on every cycle:

- the write strobe never asserts outside a selected, output-disabled window;
- the output strobe and the bus driver never overlap;
- address and write data stay stable while the selects are active;
- the write strobe lasts long enough;
- the read strobe is a single cycle;
- the idle outputs are correct whenever ready is high.

Some behaviour only the bench scenarios can show. A behavioural memory measures times in nanoseconds: pulse width, data setup, address-to-end-of-write and select-to-select spacing. It returns a corrupted byte for any read sampled before the access and output-enable times have passed, so a phase that is too short surfaces as a read-back mismatch. The bench also checks three further points: the exact transfer lengths, that a request held while busy is dropped, and that reads and writes across the address range return the right bytes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_ACCESS  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    SP_CYCLE,    // cycle time == access time
    SP_WPULSE,   // write strobe width
    SP_ADDR_END, // address / select valid to end of write
    SP_DSETUP,   // data valid to end of write
    SP_OE_ACC,   // output strobe to valid data
    SP_RELEASE   // outputs to high impedance
  } spec_e;

  function automatic int spec_ns(input int grade, input spec_e item);
    int g;
    g = (grade < 0) ? 0 : ((grade > 2) ? 2 : grade);
    case (item)
      SP_CYCLE:    return (g == 0) ? 70 : ((g == 1) ? 100 : 120);
      SP_WPULSE:   return (g == 0) ? 40 : ((g == 1) ? 60 : 70);
      SP_ADDR_END: return (g == 0) ? 60 : ((g == 1) ? 80 : 85);
      SP_DSETUP:   return (g == 0) ? 30 : ((g == 1) ? 40 : 50);
      SP_OE_ACC:   return (g == 0) ? 35 : ((g == 1) ? 50 : 60);
      default:     return (g == 0) ? 30 : ((g == 1) ? 35 : 40);
    endcase
  endfunction

  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int phase_cycles(input int grade, input int period,
                                      input bit is_wr, input phase_e ph);
    int acc, set, rec, t;
    if (is_wr) begin
      acc = at_least_one(ns_to_cyc(spec_ns(grade, SP_WPULSE), period));
      t   = ns_to_cyc(spec_ns(grade, SP_ADDR_END), period);
      if (ns_to_cyc(spec_ns(grade, SP_DSETUP), period) > t)
        t = ns_to_cyc(spec_ns(grade, SP_DSETUP), period);
      set = at_least_one(t - acc);
      rec = at_least_one(ns_to_cyc(spec_ns(grade, SP_CYCLE), period) - set - acc);
    end else begin
      acc = at_least_one(ns_to_cyc(spec_ns(grade, SP_OE_ACC), period));
      set = at_least_one(ns_to_cyc(spec_ns(grade, SP_CYCLE), period) - acc);
      rec = ns_to_cyc(spec_ns(grade, SP_CYCLE), period) - set - acc;
      if (ns_to_cyc(spec_ns(grade, SP_RELEASE), period) > rec)
        rec = ns_to_cyc(spec_ns(grade, SP_RELEASE), period);
      rec = at_least_one(rec);
    end
    case (ph)
      PH_SETUP:  return set;
      PH_ACCESS: return acc;
      default:   return rec;
    endcase
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_xfer_regs.sv
module sram_xfer_regs #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] bus_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= bus_i;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,   // 0: 70 ns, 1: 100 ns, 2: 120 ns
  parameter int AW            = 13,
  parameter int DW            = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          mem_cs_n_o,
  output logic          mem_cs_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_data_oe_o,
  input  logic [DW-1:0] mem_data_i
);
  localparam int WR_SET = phase_cycles(SPEED_GRADE, CLK_PERIOD_NS, 1'b1, PH_SETUP);
  localparam int WR_ACC = phase_cycles(SPEED_GRADE, CLK_PERIOD_NS, 1'b1, PH_ACCESS);
  localparam int WR_REC = phase_cycles(SPEED_GRADE, CLK_PERIOD_NS, 1'b1, PH_RECOVER);
  localparam int RD_SET = phase_cycles(SPEED_GRADE, CLK_PERIOD_NS, 1'b0, PH_SETUP);
  localparam int RD_ACC = phase_cycles(SPEED_GRADE, CLK_PERIOD_NS, 1'b0, PH_ACCESS);
  localparam int RD_REC = phase_cycles(SPEED_GRADE, CLK_PERIOD_NS, 1'b0, PH_RECOVER);
  localparam int MAX_LEN = (WR_SET + WR_ACC + WR_REC > RD_SET + RD_ACC + RD_REC) ?
                           WR_SET + WR_ACC + WR_REC : RD_SET + RD_ACC + RD_REC;
  localparam int CW = $clog2(MAX_LEN + 1);

  phase_e        state_q, state_d;
  logic          wr_q, wr_d;
  logic          load, last, accept, capture;
  logic [CW-1:0] len;
  logic          cs_n_q, cs_q, we_n_q, oe_n_q, drv_q, sel_d;

  assign accept  = (state_q == PH_IDLE) && req_i;
  assign ready_o = (state_q == PH_IDLE);

  always_comb begin
    state_d = state_q;
    wr_d    = accept ? wr_i : wr_q;
    load    = 1'b0;
    len     = '0;
    capture = 1'b0;
    unique case (state_q)
      PH_IDLE: if (req_i) begin
        state_d = PH_SETUP;
        load    = 1'b1;
        len     = wr_i ? CW'(WR_SET) : CW'(RD_SET);
      end
      PH_SETUP: if (last) begin
        state_d = PH_ACCESS;
        load    = 1'b1;
        len     = wr_q ? CW'(WR_ACC) : CW'(RD_ACC);
      end
      PH_ACCESS: if (last) begin
        state_d = PH_RECOVER;
        load    = 1'b1;
        len     = wr_q ? CW'(WR_REC) : CW'(RD_REC);
        capture = !wr_q;
      end
      PH_RECOVER: if (last) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  assign sel_d = (state_d == PH_SETUP) || (state_d == PH_ACCESS);

  // memory strobes registered from the next phase: no decode glitches on pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      wr_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      cs_q    <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
      cs_n_q  <= !sel_d;
      cs_q    <= sel_d;
      we_n_q  <= !((state_d == PH_ACCESS) && wr_d);
      oe_n_q  <= !((state_d == PH_ACCESS) && !wr_d);
      drv_q   <= sel_d && wr_d;
    end
  end

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .len_i  (len),
    .last_o (last)
  );

  sram_xfer_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .bus_i     (mem_data_i),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_data_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  assign mem_cs_n_o    = cs_n_q;
  assign mem_cs_o      = cs_q;
  assign mem_we_n_o    = we_n_q;
  assign mem_oe_n_o    = oe_n_q;
  assign mem_data_oe_o = drv_q;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int SPEED_GRADE   = 0,
  parameter int AW            = 13,
  parameter int DW            = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_o,
  input logic          rvalid_o,
  input logic          mem_cs_n_o,
  input logic          mem_cs_o,
  input logic          mem_we_n_o,
  input logic          mem_oe_n_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          mem_data_oe_o
);
  localparam int WP_CYC = phase_cycles(SPEED_GRADE, CLK_PERIOD_NS, 1'b1, PH_ACCESS);

  logic [15:0] wlen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wlen_q <= '0;
    else if (!mem_we_n_o) wlen_q <= wlen_q + 16'd1;
    else                  wlen_q <= '0;
  end

  a_r1_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs_n_o && !mem_cs_o && mem_we_n_o && mem_oe_n_o && !mem_data_oe_o));

  a_r3_we_inside_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_cs_n_o && mem_cs_o && mem_oe_n_o));

  a_r3_we_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (wlen_q >= 16'(WP_CYC)));

  a_r4_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));

  a_r4_wdata_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_data_oe_o && $past(mem_data_oe_o)) |-> $stable(mem_data_o));

  a_r5_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_cs_n_o && mem_cs_o));

  a_r6_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r8_no_bus_fight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_data_oe_o |-> (mem_oe_n_o && !mem_cs_n_o));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SPEED_GRADE   (SPEED_GRADE),
  .AW            (AW),
  .DW            (DW)
) u_chk (.*);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;
  localparam int AW = 13, DW = 8, PERIOD = 10, HALF = 5;
  // grade 0 limits, taken from the requirements
  localparam longint L_CYC = 70, L_WP = 40, L_AEND = 60, L_DSU = 30, L_OE = 35, L_REL = 30;

  function automatic int cyc(input longint ns);
    int c = int'((ns + PERIOD - 1) / PERIOD);
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction
  localparam int W_ACC = cyc(L_WP);
  localparam int W_SET = mx1(cyc(L_AEND) - W_ACC);
  localparam int W_LEN = W_SET + W_ACC + mx1(cyc(L_CYC) - W_SET - W_ACC);
  localparam int R_ACC = cyc(L_OE);
  localparam int R_SET = mx1(cyc(L_CYC) - R_ACC);
  localparam int R_REC0 = cyc(L_CYC) - R_SET - R_ACC;
  localparam int R_LEN = R_SET + R_ACC + mx1((cyc(L_REL) > R_REC0) ? cyc(L_REL) : R_REC0);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready_o, rvalid_o, cs_n, cs, we_n, oe_n, drv;
  logic [DW-1:0] rdata_o, dq_o, bus;
  logic [AW-1:0] maddr;
  logic m_drv = 1'b0;
  logic [DW-1:0] m_dout = '0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] sb[int];
  logic [DW-1:0] marr[int];

  always #HALF clk = ~clk;
  assign bus = drv ? dq_o : (m_drv ? m_dout : '0);

  sram_async_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .mem_cs_n_o(cs_n), .mem_cs_o(cs), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_addr_o(maddr), .mem_data_o(dq_o), .mem_data_oe_o(drv), .mem_data_i(bus));

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // behavioural memory: strobes only move at posedges, so negedge sampling
  // timestamps them exactly (edge time = now - HALF)
  longint t_sel = 0, t_wst = 0, t_adr = 0, t_dat = 0, t_oe = 0, t_rdoff = 0;
  bit sel_seen = 1'b0, rd_seen = 1'b0;
  logic p_sel = 1'b0, p_wact = 1'b0, p_rd = 1'b0, p_drv = 1'b0, p_oe_n = 1'b1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_data = '0;

  always @(negedge clk) begin
    longint te;
    logic sel, wact, rd;
    te   = longint'($time) - HALF;
    sel  = !cs_n && cs;
    wact = sel && !we_n;
    rd   = sel && we_n && !oe_n;
    if (rst_n) begin
      if (sel && !p_sel) begin
        if (sel_seen) check(te - t_sel >= L_CYC, "R7 select spacing", te - t_sel, L_CYC);
        t_sel = te; sel_seen = 1'b1;
      end
      if (!wact && p_wact) begin
        check(te - t_wst >= L_WP,   "R3 write pulse", te - t_wst, L_WP);
        check(te - t_dat >= L_DSU,  "R4 data setup", te - t_dat, L_DSU);
        check(te - t_adr >= L_AEND, "R4 address to end of write", te - t_adr, L_AEND);
        check(p_drv, "R8 data driven to end of write", p_drv, 1);
        marr[int'(p_addr)] = p_data;
      end
      if (wact && !p_wact) t_wst = te;
      if (maddr != p_addr) t_adr = te;
      if (drv && (!p_drv || dq_o != p_data)) t_dat = te;
      if (!oe_n && p_oe_n) t_oe = te;
      if (!rd && p_rd) begin t_rdoff = te; rd_seen = 1'b1; end
      if (sel && !we_n && !oe_n) check(1'b0, "R3 write with output enabled", 1, 0);
      m_drv = rd || (rd_seen && (te - t_rdoff < L_REL));
      if (rd) begin
        logic [DW-1:0] v;
        v = marr.exists(int'(maddr)) ? marr[int'(maddr)] : '0;
        // value seen at the coming posedge: corrupt if sampled too early (R5)
        m_dout = ((te + PERIOD - t_adr >= L_CYC) && (te + PERIOD - t_sel >= L_CYC) &&
                  (te + PERIOD - t_oe >= L_OE)) ? v : ~v;
      end
      if (drv && m_drv) check(1'b0, "R8 bus contention", 1, 0);
    end
    p_sel = sel; p_wact = wact; p_rd = rd; p_drv = drv; p_oe_n = oe_n;
    p_addr = maddr; p_data = dq_o;
  end

  // monitor: pops scoreboard on every read strobe
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rvalid_o) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected rvalid", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rdata_o == e, "R5/R6 read data", rdata_o, e);
        end
        @(negedge clk);
        check(!rvalid_o, "R6 rvalid one cycle", rvalid_o, 0);
      end
    end
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit noise, output int cycles);
    @(negedge clk);
    while (!ready_o) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    if (w) sb[int'(a)] = d;
    else exp_q.push_back(sb.exists(int'(a)) ? sb[int'(a)] : '0);
    @(posedge clk);
    cycles = 0;
    forever begin
      @(negedge clk);
      if (ready_o) break;
      if (noise) begin req = 1'b1; wr = 1'b1; addr = 13'h0777; wdata = 8'h99; end
      else req = 1'b0;
      @(posedge clk);
      cycles++;
    end
    req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check(ready_o && cs_n && !cs && we_n && oe_n && !drv && !rvalid_o,
          "R1 outputs in reset", {ready_o, cs_n, cs, we_n, oe_n, drv, rvalid_o}, 7'b1101100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(ready_o && cs_n && !cs && we_n && oe_n && !drv && !rvalid_o,
          "R1 idle after reset", {ready_o, cs_n, cs, we_n, oe_n, drv, rvalid_o}, 7'b1101100);

    issue(1'b1, 13'h0000, 8'hA5, 1'b0, c); check(c == W_LEN, "R9 write length", c, W_LEN);
    issue(1'b0, 13'h0000, 8'h00, 1'b0, c); check(c == R_LEN, "R9 read length", c, R_LEN);
    check(ready_o && cs_n && !cs && !drv, "R1 idle after read", {ready_o, cs_n, cs, drv}, 4'b1100);
    issue(1'b1, 13'h1FFF, 8'h5A, 1'b0, c);
    issue(1'b1, 13'h0AAA, 8'hFF, 1'b0, c);
    issue(1'b1, 13'h1555, 8'h00, 1'b0, c);
    issue(1'b0, 13'h1FFF, 8'h00, 1'b0, c);
    issue(1'b0, 13'h0AAA, 8'h00, 1'b0, c);
    issue(1'b0, 13'h1555, 8'h00, 1'b0, c);
    // R2: request held while busy must not reach the memory
    issue(1'b1, 13'h0777, 8'h11, 1'b0, c);
    issue(1'b1, 13'h0123, 8'h3C, 1'b1, c);
    check(c == W_LEN, "R2 busy request ignored, length", c, W_LEN);
    issue(1'b0, 13'h0777, 8'h00, 1'b0, c);
    issue(1'b0, 13'h0123, 8'h00, 1'b0, c);
    for (int i = 0; i < 8; i++) issue(1'b1, AW'(i * 1021), DW'(i * 37 + 5), 1'b0, c);
    for (int i = 7; i >= 0; i--) issue(1'b0, AW'(i * 1021), 8'h00, 1'b0, c);
    issue(1'b1, 13'h0000, 8'hC3, 1'b0, c);
    issue(1'b0, 13'h0000, 8'h00, 1'b0, c);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 every read strobed", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule